// File: doc/BRIEF.md
# SPI Flash Command Engine

This block is a memory-mapped peripheral that runs one complete serial-flash command each time software asks for one. Software first loads a word that packs an 8-bit command opcode with a 24-bit flash address. It can also load a 32-bit data word. It then writes a control word that gives how many bytes to send and how many to receive, with a start bit set. From that single write the engine drives chip select, the serial clock and the outgoing data line on its own. It sends the requested bytes, collects up to four reply bytes, and leaves them in the data register.

Software learns that the command has finished by polling a busy flag in the control register. The serial clock is the system clock divided by a fixed even ratio set by a parameter. The bus runs in SPI mode 0. No per-byte handshake with software is needed, so a status read, a signature read, an erase or a page program is each one control write followed by polling.

Top module: `spi_cmd_engine`

## Requirements
- R1: The register port decodes three word registers: 0 = opcode/address, 1 = control, 2 = data. After reset, all three read as zero, chip select is high and the serial clock is low.
- R2: The opcode/address register holds the opcode in bits 7:0 and the 24-bit flash address in bits 31:8, and reads back as written.
- R3: Control bits 3:0 hold the transmit byte count and bits 7:4 the receive byte count. Bit 8 is a write-only start bit that reads as 0. Bit 16 reads as busy. A control write with start set and a non-zero transmit count begins a transaction on the following clock edge, and busy reads 1 until chip select is released.
- R4: The transmit count includes the opcode. The bytes go out in this order: the opcode, then address bits 31:24, 23:16 and 15:8, then data-register lanes 0, 1, 2 and 3. Each byte is sent most significant bit first, and only the first transmit-count bytes are sent.
- R5: The k-th received byte lands in data lane k (bits 8k+7:8k). Lanes at or above the receive count read 0 after the transaction. The outgoing data line is 0 while bytes are being received.
- R6: SPI mode 0. The serial clock idles low. Outgoing data changes only on falling clock edges. Incoming data is sampled on rising edges. The clock period is 2*SCK_HALF system clocks.
- R7: Chip select stays low without a break for all transmit bytes followed by all receive bytes. It rises one serial-clock period after the last rising edge, so busy lasts exactly (16*(tx+rx)+1)*SCK_HALF clocks.
- R8: A start request with a transmit count of 0 starts nothing: busy stays 0, chip select stays high and the data register is unchanged.
- R9: A transmit count above 8 is clamped to 8 and a receive count above 4 is clamped to 4. The control register reads back the clamped values.
- R10: While busy, every register write, including a new start request, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest state to reach is a register write that arrives in the middle of a transfer. Such a write would change the data being shifted, restart chip select or alter the counts. To reach it, the bench issues a data write and then a new start request on fixed cycles while it is polling busy, during a command that both sends and receives. It then checks the control readback, the data lanes, the number of chip-select falls and the busy duration. A serial-flash model in the bench records every bit on the outgoing line and drives a known reply, so bytes are checked in both directions. The reply model drives ones during the transmit phase, which exposes any receive data captured too early. A start with counts of 15 and 15 exercises clamping through the longest possible frame.

// File: rtl/spi_cmd_pkg.sv
// Package: shared constants, register decode and helpers for the SPI
// command engine. Assumes a 32-bit register port and byte-wide lanes.
package spi_cmd_pkg;

    localparam int DW       = 32;                       // register width
    localparam int LANES    = DW / 8;                   // data byte lanes
    localparam int LANE_W   = $clog2(LANES);
    localparam int MAX_TX   = 8;                        // opcode+addr+data
    localparam int MAX_RX   = LANES;
    localparam int CNT_W    = 4;                        // control count field
    localparam int TOT_W    = $clog2(MAX_TX + MAX_RX + 1);
    localparam int BIT_W    = TOT_W + 3;                // frame bit index
    localparam int FRAME_W  = 8 * MAX_TX;

    localparam logic [1:0] ADDR_OPADDR = 2'd0;
    localparam logic [1:0] ADDR_CTRL   = 2'd1;
    localparam logic [1:0] ADDR_DATA   = 2'd2;

    localparam int CTRL_START_BIT = 8;
    localparam int CTRL_BUSY_BIT  = 16;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_RUN  = 2'd1,
        SH_TAIL = 2'd2
    } sh_state_e;

    // Saturate a byte count at its limit.
    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] v,
                                                   input int unsigned lim);
        return (32'(v) > lim) ? CNT_W'(lim) : v;
    endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
// Register file: opcode/address, control and data registers.
// Assumes writes are single-cycle strobes; all writes are dropped while
// busy. Raises a one-cycle start with clamped counts, clears unused
// receive lanes at start and stores reply bytes from the sequencer.
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              busy,
    input  logic              lane_we,
    input  logic [LANE_W-1:0] lane_idx,
    input  logic [7:0]        lane_byte,
    output logic              start,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic [CNT_W-1:0]  rx_cnt,
    output logic [DW-1:0]     opaddr_q,
    output logic [DW-1:0]     data_q
);

    logic             wr_ok;
    logic [CNT_W-1:0] tx_q, rx_q;
    logic [7:0]       lane_q [LANES];

    // Decode an accepted write and the clamped counts it carries.
    always_comb begin
        wr_ok  = reg_we && !busy;
        tx_cnt = clamp_cnt(reg_wdata[CNT_W-1:0], MAX_TX);
        rx_cnt = clamp_cnt(reg_wdata[2*CNT_W-1:CNT_W], MAX_RX);
        start  = wr_ok && (reg_addr == ADDR_CTRL) &&
                 reg_wdata[CTRL_START_BIT] && (tx_cnt != '0);
    end

    // Opcode/address and control count storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opaddr_q <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
        end else if (wr_ok) begin
            if (reg_addr == ADDR_OPADDR) opaddr_q <= reg_wdata;
            if (reg_addr == ADDR_CTRL) begin
                tx_q <= tx_cnt;
                rx_q <= rx_cnt;
            end
        end
    end

    // One storage byte per data lane: software write, clear, or reply byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q[g] <= '0;
            else if (wr_ok && reg_addr == ADDR_DATA)
                lane_q[g] <= reg_wdata[8*g +: 8];
            else if (start && (CNT_W'(g) >= rx_cnt))
                lane_q[g] <= '0;
            else if (lane_we && lane_idx == LANE_W'(g))
                lane_q[g] <= lane_byte;
        end
        assign data_q[8*g +: 8] = lane_q[g];
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_OPADDR: reg_rdata = opaddr_q;
            ADDR_CTRL: begin
                reg_rdata[CNT_W-1:0]       = tx_q;
                reg_rdata[2*CNT_W-1:CNT_W] = rx_q;
                reg_rdata[CTRL_BUSY_BIT]   = busy;
            end
            ADDR_DATA:   reg_rdata = data_q;
            default:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/spi_cmd_seq.sv
// Byte sequencer: builds the outgoing frame in wire order (opcode,
// address high to low, data lanes low to high, unsent bytes zeroed),
// sizes the frame in bits, and packs received bits into reply bytes
// for the register file. Assumes start is a single-cycle pulse.
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   tx_cnt,
    input  logic [CNT_W-1:0]   rx_cnt,
    input  logic [DW-1:0]      opaddr,
    input  logic [DW-1:0]      data,
    input  logic               sample,
    input  logic [BIT_W-1:0]   bit_idx,
    input  logic               miso,
    output logic [FRAME_W-1:0] frame,
    output logic [BIT_W-1:0]   total_bits,
    output logic               lane_we,
    output logic [LANE_W-1:0]  lane_idx,
    output logic [7:0]         lane_byte
);

    logic [BIT_W-1:0] tx_bits_q;
    logic [BIT_W-1:0] rx_rel;
    logic             in_rx;
    logic [6:0]       rx_sh;
    logic [TOT_W-1:0] byte_sum;

    // Place each outgoing byte in the frame; the byte source depends on slot.
    for (genvar b = 0; b < MAX_TX; b++) begin : g_slot
        logic [7:0] src;
        if (b == 0) begin : g_op
            assign src = opaddr[7:0];
        end else if (b < 4) begin : g_addr
            assign src = opaddr[8*(4-b) +: 8];
        end else begin : g_data
            assign src = data[8*(b-4) +: 8];
        end
        assign frame[FRAME_W-1-8*b -: 8] = (CNT_W'(b) < tx_cnt) ? src : 8'h00;
    end

    // Frame length in bits.
    always_comb begin
        byte_sum   = TOT_W'(tx_cnt) + TOT_W'(rx_cnt);
        total_bits = {byte_sum, 3'b000};
    end

    // Classify the sampled bit and form a completed reply byte.
    always_comb begin
        in_rx     = bit_idx >= tx_bits_q;
        rx_rel    = bit_idx - tx_bits_q;
        lane_we   = sample && in_rx && (rx_rel[2:0] == 3'd7);
        lane_idx  = rx_rel[3 +: LANE_W];
        lane_byte = {rx_sh, miso};
    end

    // Remember the transmit length and shift in receive bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bits_q <= '0;
            rx_sh     <= '0;
        end else begin
            if (start) tx_bits_q <= {TOT_W'(tx_cnt), 3'b000};
            if (sample && in_rx) rx_sh <= {rx_sh[5:0], miso};
        end
    end

endmodule

// File: rtl/spi_cmd_shift.sv
// SPI bit shifter, mode 0: owns chip select, serial clock and the outgoing
// data line. Runs total_bits clock periods of 2*SCK_HALF system clocks,
// then holds chip select low one more half period after the last falling
// edge. Assumes total_bits is non-zero when start pulses.
module spi_cmd_shift
    import spi_cmd_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [BIT_W-1:0]   total_bits,
    output logic               cs_n,
    output logic               sck,
    output logic               mosi,
    output logic               sample,
    output logic [BIT_W-1:0]   bit_idx,
    output logic               busy
);

    localparam int DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    sh_state_e          state_q;
    logic [DIV_W-1:0]   div_q;
    logic               tick;
    logic               last_bit;
    logic [FRAME_W-1:0] sh_q;
    logic [BIT_W-1:0]   total_q;

    // Half-period tick and frame-end detection.
    always_comb begin
        tick     = (div_q == DIV_W'(SCK_HALF - 1));
        last_bit = (bit_idx == total_q - BIT_W'(1));
        sample   = (state_q == SH_RUN) && tick && !sck;
        busy     = (state_q != SH_IDLE);
        mosi     = busy && sh_q[FRAME_W-1];
    end

    // Half-period divider, held at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == SH_IDLE) div_q <= '0;
        else if (tick)                    div_q <= '0;
        else                              div_q <= div_q + DIV_W'(1);
    end

    // Pin sequencing: select, clock toggling, shifting and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            cs_n    <= 1'b1;
            sck     <= 1'b0;
            sh_q    <= '0;
            bit_idx <= '0;
            total_q <= '0;
        end else begin
            case (state_q)
                SH_IDLE: if (start) begin
                    state_q <= SH_RUN;
                    cs_n    <= 1'b0;
                    sck     <= 1'b0;
                    sh_q    <= frame;
                    bit_idx <= '0;
                    total_q <= total_bits;
                end
                SH_RUN: if (tick) begin
                    sck <= !sck;
                    if (sck) begin
                        if (last_bit) begin
                            state_q <= SH_TAIL;
                        end else begin
                            bit_idx <= bit_idx + BIT_W'(1);
                            sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
                        end
                    end
                end
                SH_TAIL: if (tick) begin
                    state_q <= SH_IDLE;
                    cs_n    <= 1'b1;
                end
                default: state_q <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/spi_cmd_engine.sv
// Top level: register-driven SPI flash command engine. One control write
// with the start bit runs a full command of up to 8 transmit and 4
// receive bytes. Serial clock is clk / (2*SCK_HALF); SCK_HALF >= 1.
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          spi_cs_n,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso
);

    logic               busy;
    logic               start;
    logic [CNT_W-1:0]   tx_cnt, rx_cnt;
    logic [DW-1:0]      opaddr_q, data_q;
    logic [FRAME_W-1:0] frame;
    logic [BIT_W-1:0]   total_bits, bit_idx;
    logic               sample;
    logic               lane_we;
    logic [LANE_W-1:0]  lane_idx;
    logic [7:0]         lane_byte;

    spi_cmd_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .busy     (busy),
        .lane_we  (lane_we),
        .lane_idx (lane_idx),
        .lane_byte(lane_byte),
        .start    (start),
        .tx_cnt   (tx_cnt),
        .rx_cnt   (rx_cnt),
        .opaddr_q (opaddr_q),
        .data_q   (data_q)
    );

    spi_cmd_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tx_cnt    (tx_cnt),
        .rx_cnt    (rx_cnt),
        .opaddr    (opaddr_q),
        .data      (data_q),
        .sample    (sample),
        .bit_idx   (bit_idx),
        .miso      (spi_miso),
        .frame     (frame),
        .total_bits(total_bits),
        .lane_we   (lane_we),
        .lane_idx  (lane_idx),
        .lane_byte (lane_byte)
    );

    spi_cmd_shift #(.SCK_HALF(SCK_HALF)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frame     (frame),
        .total_bits(total_bits),
        .cs_n      (spi_cs_n),
        .sck       (spi_sck),
        .mosi      (spi_mosi),
        .sample    (sample),
        .bit_idx   (bit_idx),
        .busy      (busy)
    );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
// Checker for spi_cmd_engine: protocol and handshake properties on the
// pins and the internal busy flag. Attached by the bind below.
module spi_cmd_engine_chk
    import spi_cmd_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [1:0]    reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic          spi_cs_n,
    input logic          spi_sck,
    input logic          spi_mosi,
    input logic          busy
);

    // R6: serial clock idles low whenever the flash is deselected.
    a_r6_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // R6: inside a frame the data line moves only with a falling clock.
    a_r6_mosi_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && $past(!spi_cs_n) && !($past(spi_sck) && !spi_sck))
        |-> $stable(spi_mosi));

    // R7: busy flag and chip select agree.
    a_r7_busy_tracks_cs: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !spi_cs_n);

    // R3: an accepted start with a non-zero transmit count raises busy.
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !busy && reg_addr == ADDR_CTRL && reg_wdata[CTRL_START_BIT]
         && reg_wdata[CNT_W-1:0] != '0) |=> busy);

    // R8: a start with a zero transmit count leaves the engine idle.
    a_r8_zero_tx_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !busy && reg_addr == ADDR_CTRL && reg_wdata[CNT_W-1:0] == '0)
        |=> (!busy && spi_cs_n));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .spi_cs_n (spi_cs_n),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .busy     (busy)
);

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;
    import spi_cmd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        spi_cs_n, spi_sck, spi_mosi;
    logic        spi_miso = 1'b1;

    int checks = 0;
    int errors = 0;

    spi_cmd_engine #(.SCK_HALF(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Flash model: records outgoing bits and drives the reply.
    logic        cap [128];
    int          cap_n = 0;
    int          cs_falls = 0;
    int          cur_tx = 0;
    logic [31:0] cur_reply = '0;

    function automatic logic reply_bit(input int i);
        int j;
        if (i < 8*cur_tx) return 1'b1;
        j = i - 8*cur_tx;
        if (j >= 32) return 1'b1;
        return cur_reply[8*(j/8) + 7 - (j%8)];
    endfunction

    always @(negedge spi_cs_n) begin
        cap_n    = 0;
        cs_falls = cs_falls + 1;
        spi_miso = reply_bit(0);
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (cap_n < 128) cap[cap_n] = spi_mosi;
        cap_n = cap_n + 1;
    end
    always @(negedge spi_sck) if (!spi_cs_n) spi_miso = reply_bit(cap_n);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] tx_byte(input int b, input logic [31:0] oa,
                                           input logic [31:0] dt);
        if (b == 0) return oa[7:0];
        if (b < 4)  return oa[8*(4-b) +: 8];
        return dt[8*(b-4) +: 8];
    endfunction

    // Runs one command; tx_w/rx_w are as written (before clamping).
    task automatic run_txn(input int tx_w, input int rx_w, input logic [31:0] oa,
                           input logic [31:0] dt, input logic [31:0] reply,
                           input bit meddle, input string tag);
        int tx, rx, cycles, bad, exp_cyc;
        logic busy_s;
        logic [31:0] got, exp_d, exp_bit;
        tx = (tx_w > 8) ? 8 : tx_w;
        rx = (rx_w > 4) ? 4 : rx_w;
        wr(ADDR_OPADDR, oa);
        wr(ADDR_DATA, dt);
        cur_tx = tx; cur_reply = reply; cs_falls = 0;
        @(negedge clk);
        reg_addr = ADDR_CTRL;
        reg_wdata = 32'h100 | 32'(rx_w << 4) | 32'(tx_w);
        reg_we = 1'b1;
        @(posedge clk);
        #1 reg_we = 1'b0;
        cycles = 0;
        do begin
            @(posedge clk);
            #1 reg_we = 1'b0; reg_addr = ADDR_CTRL;
            #1 busy_s = reg_rdata[16];
            cycles++;
            if (cycles == 2) begin
                // R9: clamped counts visible while busy
                check(reg_rdata[7:0] == 8'((rx << 4) | tx) && busy_s, "R9",
                      {tag, " ctrl readback while busy"}, reg_rdata,
                      32'h10000 | 32'((rx << 4) | tx));
            end
            if (meddle && cycles == 3) begin
                reg_addr = ADDR_DATA; reg_wdata = 32'hCAFEF00D; reg_we = 1'b1;
            end
            if (meddle && cycles == 4) begin
                reg_addr = ADDR_CTRL; reg_wdata = 32'h0000_01F1; reg_we = 1'b1;
            end
        end while (busy_s && cycles < 5000);
        reg_we = 1'b0;
        exp_cyc = (16*(tx+rx) + 1) * HALF;
        check(cycles == exp_cyc, "R7", {tag, " busy duration"}, cycles, exp_cyc);
        check(cs_falls == 1, "R7", {tag, " single chip-select frame"}, cs_falls, 1);
        // R4 / R5: outgoing stream
        bad = -1;
        for (int i = 0; i < 8*(tx+rx); i++) begin
            exp_bit = (i < 8*tx) ? 32'(tx_byte(i/8, oa, dt)[7 - (i%8)]) : 32'd0;
            if (bad < 0 && 32'(cap[i]) != exp_bit) bad = i;
        end
        check(cap_n == 8*(tx+rx), "R4", {tag, " bit count"}, cap_n, 8*(tx+rx));
        check(bad < 0, "R4", {tag, " first bad outgoing bit index"}, bad, -1);
        exp_d = '0;
        for (int k = 0; k < rx; k++) exp_d[8*k +: 8] = reply[8*k +: 8];
        rd(ADDR_DATA, got);
        check(got == exp_d, "R5", {tag, " data register"}, got, exp_d);
        rd(ADDR_CTRL, got);
        check(got == 32'((rx << 4) | tx), "R10", {tag, " ctrl after frame"}, got,
              32'((rx << 4) | tx));
    endtask

    typedef struct packed {
        logic [3:0]  tx;
        logic [3:0]  rx;
        logic [31:0] oa;
        logic [31:0] dt;
        logic [31:0] reply;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{4'd1, 4'd0, 32'h0000_0006, 32'h1111_1111, 32'h0000_0000},
        '{4'd1, 4'd1, 32'h0000_0005, 32'h2222_2222, 32'h0000_00A5},
        '{4'd4, 4'd4, 32'h1234_5603, 32'h0000_0000, 32'hDEAD_BEEF},
        '{4'd8, 4'd0, 32'hABCD_EF02, 32'h4433_2211, 32'h0000_0000},
        '{4'd4, 4'd1, 32'h0000_00AB, 32'h0000_0000, 32'h0000_0013},
        '{4'd5, 4'd0, 32'h0000_010B, 32'h9988_7766, 32'h0000_0000},
        '{4'd4, 4'd0, 32'h00FF_00D8, 32'hFFFF_FFFF, 32'h0000_0000},
        '{4'd2, 4'd3, 32'h8040_2011, 32'h0A0B_0C0D, 32'h00C0_FFEE}
    };

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int idle_bad;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(ADDR_OPADDR, v); check(v == 0, "R1", "opaddr after reset", v, 0);
        rd(ADDR_CTRL, v);   check(v == 0, "R1", "ctrl after reset", v, 0);
        rd(ADDR_DATA, v);   check(v == 0, "R1", "data after reset", v, 0);
        check(spi_cs_n && !spi_sck, "R1", "pins after reset",
              {30'd0, spi_cs_n, spi_sck}, 32'd2);

        // R2: opcode/address register readback
        wr(ADDR_OPADDR, 32'hFEDC_BA9F);
        rd(ADDR_OPADDR, v); check(v == 32'hFEDC_BA9F, "R2", "opaddr readback", v, 32'hFEDC_BA9F);

        // R3..R7: vector table
        for (int n = 0; n < 8; n++)
            run_txn(int'(VEC[n].tx), int'(VEC[n].rx), VEC[n].oa, VEC[n].dt,
                    VEC[n].reply, 1'b0, $sformatf("vec%0d", n));

        // R8: zero transmit count starts nothing
        wr(ADDR_DATA, 32'h5A5A_5A5A);
        cs_falls = 0;
        wr(ADDR_CTRL, 32'h0000_0120);
        idle_bad = 0;
        for (int i = 0; i < 12; i++) begin
            rd(ADDR_CTRL, v);
            if (v[16] || !spi_cs_n) idle_bad++;
        end
        check(idle_bad == 0 && cs_falls == 0, "R8", "no frame on zero tx", idle_bad, 0);
        rd(ADDR_DATA, v); check(v == 32'h5A5A_5A5A, "R8", "data untouched", v, 32'h5A5A_5A5A);

        // R9: counts of 15/15 clamp to 8/4
        run_txn(15, 15, 32'h7654_3203, 32'h0102_0304, 32'h8877_6655, 1'b0, "clamp");

        // R10: writes during a frame are ignored
        run_txn(4, 2, 32'h00AB_CD0B, 32'h1357_9BDF, 32'h0000_3C69, 1'b1, "meddle");
        rd(ADDR_OPADDR, v); check(v == 32'h00AB_CD0B, "R10", "opaddr kept", v, 32'h00AB_CD0B);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule